// File: doc/BRIEF.md
# Master/Slave PWM Output Pair

This block pairs two down-counting timer channels to drive one PWM output. The master channel sets the period and the slave channel sets the active width. Both channels advance only on a one-cycle count strobe that a prescaler outside the block produces. At its terminal count the master raises a one-cycle interrupt pulse, reloads itself and restarts the slave. The slave raises its own pulse when its count runs out, and it does so at most once per period.

The slave output is driven as a set/reset flop. The reset request comes from the slave pulse. The set request comes from the master pulse, held back by one count tick. A reset that arrives in the same tick as a set always wins. Because of this, a zero duty value keeps the output inactive, and a duty value past the period keeps it active with no break at the period edges. The master's own output toggles on each master pulse. Each output has an enable bit and an inversion bit.

Top module: `pwm_pair_ctrl`

## Requirements
- R1: After reset, before any count tick, both internal output levels are 0 (so each output equals its inversion bit) and neither interrupt pulse is high.
- R2: With period value P, the master pulse `m_irq` is high during the first count tick after reset and then on every (P+1)th tick, for a single cycle, and only while `tick` is high.
- R3: On a cycle where `tick` is low, neither interrupt pulse is high and neither output changes at the following clock edge.
- R4: With duty value D at most P, the slave pulse `s_irq` fires on the tick D+1 ticks after each master pulse, which can be the same tick as the next master pulse. It fires at most once per period, and never when D exceeds P.
- R5: The set request of a master pulse reaches the slave output one count tick later: the level stays inactive after the master-pulse tick and becomes active after the next tick (when D is not 0).
- R6: When a set and a reset fall on the same tick, the reset wins. So with D = 0 the slave output stays inactive for the whole run.
- R7: With D >= P+1 the slave output becomes active one tick after the first master pulse and then stays active with no inactive cycle at period boundaries.
- R8: With 1 <= D <= P the slave output is active for exactly D ticks out of every P+1 ticks.
- R9: The master output inverts on every master pulse while its enable is 1.
- R10: An output drives its internal level when its inversion bit is 0 and the complement of that level when the bit is 1.
- R11: While an output's enable bit is 0, its level holds and all set, reset and toggle requests for it are ignored. The interrupt pulses keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-clock strobe, one cycle wide |
| period_cmp | input | CW | Master compare value P; period is P+1 ticks |
| duty_cmp | input | CW | Slave compare value D; active width in ticks |
| m_oe | input | 1 | Master output enable |
| m_inv | input | 1 | Master output inversion |
| s_oe | input | 1 | Slave output enable |
| s_inv | input | 1 | Slave output inversion |
| m_irq | output | 1 | Master terminal-count pulse |
| s_irq | output | 1 | Slave terminal-count pulse |
| m_out | output | 1 | Master toggle output |
| s_out | output | 1 | PWM output |

## Verification
The main function is run with duty at zero, at exactly P+1 and well past the period, at P, at one, and at random values in between. Each of these cases falls on a different path where the delayed set meets the slave reset. A zero duty shows whether the reset outranks a set in the same tick. Duty at P shows whether a slave pulse that lands on the next master pulse still ends the active phase. Duty past the period shows whether the output holds with no glitch when the slave never fires. Strobe divisors from one to three, random inversion bits, and an enable drop in mid-run test the gating of counts and the holding of the level.

// File: rtl/pwm_pair_ctrl.sv
module pwm_pair_ctrl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] period_cmp,
  input  logic [CW-1:0] duty_cmp,
  input  logic          m_oe,
  input  logic          m_inv,
  input  logic          s_oe,
  input  logic          s_inv,
  output logic          m_irq,
  output logic          s_irq,
  output logic          m_out,
  output logic          s_out
);
  logic [CW-1:0] m_cnt, s_cnt;
  logic          s_armed, set_dly, m_lvl, s_lvl;

  assign m_irq = tick & (m_cnt == '0);
  assign s_irq = tick & s_armed & (s_cnt == '0);
  assign m_out = m_lvl ^ m_inv;
  assign s_out = s_lvl ^ s_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt   <= '0;
      s_cnt   <= '0;
      s_armed <= 1'b0;
      set_dly <= 1'b0;
      m_lvl   <= 1'b0;
      s_lvl   <= 1'b0;
    end else if (tick) begin
      m_cnt   <= m_irq ? period_cmp : m_cnt - 1'b1;
      set_dly <= m_irq;
      if (m_irq) begin
        s_cnt   <= duty_cmp;
        s_armed <= 1'b1;
      end else if (s_armed) begin
        if (s_cnt == '0) s_armed <= 1'b0;
        else             s_cnt   <= s_cnt - 1'b1;
      end
      if (m_oe && m_irq) m_lvl <= ~m_lvl;
      if (s_oe) begin
        if (s_irq)        s_lvl <= 1'b0;
        else if (set_dly) s_lvl <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_pair_ctrl_chk.sv
module pwm_pair_ctrl_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [CW-1:0] period_cmp,
  input logic          m_oe,
  input logic          m_inv,
  input logic          s_oe,
  input logic          s_inv,
  input logic          m_irq,
  input logic          s_irq,
  input logic          m_out,
  input logic          s_out
);
  logic          last_m, fired, primed;
  logic [CW:0]   tcnt;
  logic [CW-1:0] pcap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_m <= 1'b0;
      fired  <= 1'b0;
      primed <= 1'b0;
      tcnt   <= '0;
      pcap   <= '0;
    end else if (tick) begin
      last_m <= m_irq;
      if (m_irq) begin
        fired  <= 1'b0;
        primed <= 1'b1;
        tcnt   <= '0;
        pcap   <= period_cmp;
      end else begin
        tcnt <= tcnt + 1'b1;
        if (s_irq) fired <= 1'b1;
      end
    end
  end

  // R2
  master_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && primed && (tcnt == {1'b0, pcap})) |-> m_irq);
  // R2
  master_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_irq && primed) |-> (tcnt == {1'b0, pcap}));
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(m_out ^ m_inv) && $stable(s_out ^ s_inv)));
  // R4
  slave_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_irq |-> !fired);
  // R5
  delayed_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && last_m && !s_irq && s_oe) |=> (s_out ^ s_inv));
  // R6
  reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_irq && s_oe) |=> !(s_out ^ s_inv));
  // R9
  master_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_irq && m_oe) |=> ((m_out ^ m_inv) != $past(m_out ^ m_inv)));
  // R11
  slave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_oe |=> ((s_out ^ s_inv) == $past(s_out ^ s_inv)));
endmodule

bind pwm_pair_ctrl pwm_pair_ctrl_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .period_cmp(period_cmp),
  .m_oe(m_oe), .m_inv(m_inv), .s_oe(s_oe), .s_inv(s_inv),
  .m_irq(m_irq), .s_irq(s_irq), .m_out(m_out), .s_out(s_out)
);

// File: tb/pwm_pair_ctrl_test.sv
module pwm_pair_ctrl_test;
  localparam int CW = 8;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [CW-1:0] period_cmp = '0, duty_cmp = '0;
  logic m_oe = 1'b1, m_inv = 1'b0, s_oe = 1'b1, s_inv = 1'b0;
  logic m_irq, s_irq, m_out, s_out;
  int vecs = 0, bad = 0;
  bit done = 1'b0;

  pwm_pair_ctrl #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period_cmp(period_cmp),
    .duty_cmp(duty_cmp), .m_oe(m_oe), .m_inv(m_inv), .s_oe(s_oe),
    .s_inv(s_inv), .m_irq(m_irq), .s_irq(s_irq), .m_out(m_out), .s_out(s_out)
  );

  always #5 clk = ~clk;

  function automatic bit s_level(int n, int p, int d);
    return (n >= 2) && (((n - 2) % (p + 1)) < d);
  endfunction

  function automatic bit m_level(int n, int p);
    if (n == 0) return 1'b0;
    return 1'(((n - 1) / (p + 1) + 1) & 1);
  endfunction

  task automatic chk(bit act, bit exp, string req);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_seg(int p, int d, int dv, bit mi, bit si, int ncyc, int drop_at);
    int n = 0, ph = 0;
    bit frozen = 1'b0, dropped = 1'b0, prev_tick = 1'b0, prev_s = 1'b0, prev_m = 1'b0;
    bit es;
    string sreq;
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0;
    period_cmp = CW'(p); duty_cmp = CW'(d);
    m_oe = 1'b1; s_oe = 1'b1; m_inv = mi; s_inv = si;
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (c == drop_at) begin
        s_oe = 1'b0;
        dropped = 1'b1;
        frozen = s_level(n, p, d);
      end
      tick = (ph == dv - 1);
      ph = (ph == dv - 1) ? 0 : ph + 1;
      #1;
      es = dropped ? frozen : s_level(n, p, d);
      if (n == 0) sreq = "R1";
      else if (dropped) sreq = "R11";
      else if (n <= 2 && d > 0) sreq = "R5";
      else if (d == 0) sreq = "R6";
      else if (d > p) sreq = "R7";
      else sreq = "R8";
      if (si) sreq = {sreq, "/R10"};
      chk(s_out, es ^ si, sreq);
      chk(m_out, m_level(n, p) ^ mi, mi ? "R9/R10" : "R9");
      chk(m_irq, tick && ((n % (p + 1)) == 0), "R2");
      chk(s_irq, tick && n >= 1 && d <= p && (((n - 1) % (p + 1)) == d), "R4");
      if (c > 0 && !prev_tick) begin
        chk(s_out, prev_s, "R3");
        chk(m_out, prev_m, "R3");
      end
      prev_tick = tick; prev_s = s_out; prev_m = m_out;
      if (tick) n++;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    run_seg(4, 0, 1, 0, 0, 40, -1);
    run_seg(4, 5, 1, 0, 0, 40, -1);
    run_seg(4, 9, 2, 0, 1, 60, -1);
    run_seg(4, 4, 1, 1, 0, 40, -1);
    run_seg(4, 1, 3, 0, 0, 70, -1);
    run_seg(0, 0, 1, 0, 0, 12, -1);
    run_seg(0, 1, 2, 0, 0, 20, -1);
    run_seg(5, 3, 1, 0, 0, 60, 17);
    run_seg(6, 10, 1, 0, 1, 50, 9);
    for (int s = 0; s < 30; s++) begin
      int p, d, dv, mode;
      p = $urandom % 12;
      mode = $urandom % 4;
      if (mode == 0) d = 0;
      else if (mode == 1) d = p + 1 + ($urandom % 3);
      else d = 1 + ($urandom % (p + 1));
      dv = 1 + ($urandom % 3);
      run_seg(p, d, dv, 1'($urandom), 1'($urandom), (p + 1) * dv * 3 + 10,
              (($urandom % 4) == 0) ? 5 + ($urandom % 10) : -1);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      vecs++;
      bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule